// File: doc/BRIEF.md
# Dual-Channel Disk Register Address Decoder

This block sits between a host programmed-I/O port and the register files of a two-channel disk interface. Each accepted access is compared against five address windows: command and control windows for the first and second channel, and a shared bus-master window. The block reports which register class was hit, which channel it belongs to and the offset inside the window. Window bases are loaded from the configuration side through a simple write port.

For command and control accesses the block keeps one device-select flag per channel, so each channel can address a master or a slave unit. It turns every legal access into drive transfers carrying a two-bit drive number. A 32-bit access to the data port becomes two 16-bit transfers on consecutive cycles. While the second half is pending the block holds off new accesses. Disabled I/O space, empty drive slots, illegal widths and unmatched addresses are all handled without corrupting state.

Top module: `pio_window_decoder`

## Requirements
- R1: Windows are tried in this order, and the first one that matches wins: first-channel command, first-channel control, second-channel command, second-channel control, bus-master. A window matches when the base is at or below the address and the address is below base plus size. The response in the cycle after acceptance reports the class (0 command, 1 control, 2 bus-master, 3 none) and the offset, which is the address minus the base.
- R2: A bus-master window hit reports channel 0 when its offset is below `BM_CH1_OFS` and channel 1 otherwise. It never produces a drive transfer.
- R3: An 8-bit write to offset `SEL_OFS` of a command window copies bit `DEV_BIT` of the write data into that channel's select flag (0 master, 1 slave). Reads, control-window writes and wrong-width writes leave the flags unchanged.
- R4: The drive number of a transfer is channel times two plus that channel's select flag. A select write uses its new flag value for its own transfer.
- R5: While `io_en` is low, an access produces no response, no error, no transfer and no flag change.
- R6: A legal command or control access whose drive slot has its `drive_present` bit low still gives a response, but no drive transfer.
- R7: A command-window offset `DATA_OFS` (data port) access of width 16 (size code 1) gives one transfer. Width 32 (size code 2) gives two transfers on consecutive cycles: the low half first, then the high half with `drv_hi` set. `acc_ready` is low during the cycle in between.
- R8: A data-port access of width 8 (size code 0) or size code 3 raises `size_err`, as does a non-data command or control access that is not 8-bit. Bus-master accesses accept size codes 0 to 2. A size error produces no transfer and no flag change.
- R9: A base write with `base_sel` 0..4 (same order as R1) replaces that base only when `base_val` is nonzero.
- R10: An address that matches no window raises `decode_err` with class 3 and changes no state.
- R11: After reset, all pulse outputs are low, `sel_flags` is 0, `acc_ready` is high and the bases hold their reset parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_en | input | 1 | I/O space enable |
| base_wr | input | 1 | Base register write strobe |
| base_sel | input | 3 | Window to reprogram (0..4) |
| base_val | input | AW | New base value |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 write, 0 read |
| acc_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 illegal |
| acc_addr | input | AW | Access address |
| acc_wdata | input | 32 | Write data |
| drive_present | input | 4 | One bit per drive slot |
| acc_ready | output | 1 | Access may be presented |
| rsp_valid | output | 1 | Response pulse |
| rsp_class | output | 2 | Register class |
| rsp_chan | output | 1 | Channel |
| rsp_offset | output | AW | Offset within window |
| decode_err | output | 1 | No window matched |
| size_err | output | 1 | Illegal width |
| sel_flags | output | 2 | Device-select flag per channel |
| drv_valid | output | 1 | Drive transfer pulse |
| drv_write | output | 1 | Transfer direction |
| drv_idx | output | 2 | Drive number |
| drv_class | output | 2 | Class of transfer (0 or 1) |
| drv_offset | output | AW | Register offset for drive |
| drv_wdata | output | 16 | Transfer data half |
| drv_hi | output | 1 | Second half of a split access |

## Verification
The bench uses the default parameters: 16-bit addresses, windows of 8, 4 and 16 bytes, and the bus-master channel split at offset 8. With these values, every window edge and the byte just past each edge can be reached in a few accesses. The bench also moves the second command base so that it overlaps the first, which makes the window priority visible. The slot mask is changed during the run, so absent drives, all four drive numbers and the split word path are all covered.

// File: rtl/pio_dec_pkg.sv
// Shared types and window numbering for the disk register address decoder.
package pio_dec_pkg;
    typedef enum logic [1:0] {
        RC_CMD  = 2'd0,
        RC_CTRL = 2'd1,
        RC_BM   = 2'd2,
        RC_NONE = 2'd3
    } reg_class_t;

    typedef enum logic [1:0] {
        SZ_8   = 2'd0,
        SZ_16  = 2'd1,
        SZ_32  = 2'd2,
        SZ_BAD = 2'd3
    } acc_size_t;

    localparam int NWIN      = 5;
    localparam int WIN_PCMD  = 0;
    localparam int WIN_PCTL  = 1;
    localparam int WIN_SCMD  = 2;
    localparam int WIN_SCTL  = 3;
    localparam int WIN_BM    = 4;
endpackage

// File: rtl/pio_win_cmp.sv
// Single window comparator: flags base <= addr < base+SIZE and gives the
// offset. Assumes SIZE fits in AW bits; the sum is widened so it cannot wrap.
module pio_win_cmp #(
    parameter int AW   = 16,
    parameter int SIZE = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    output logic          hit,
    output logic [AW-1:0] offset
);
    localparam logic [AW:0] SIZE_W = (AW+1)'(SIZE);

    logic [AW:0] limit;

    // Range test against the widened upper bound.
    always_comb begin
        limit  = {1'b0, base} + SIZE_W;
        hit    = ({1'b0, addr} >= {1'b0, base}) && ({1'b0, addr} < limit);
        offset = addr - base;
    end
endmodule

// File: rtl/pio_base_regs.sv
// Holds the five window bases. A write loads a base only when the value is
// nonzero; selectors beyond the last window are ignored.
module pio_base_regs
    import pio_dec_pkg::*;
#(
    parameter int                     AW        = 16,
    parameter logic [NWIN*AW-1:0]     RST_BASES = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [2:0]                sel,
    input  logic [AW-1:0]             val,
    output logic [NWIN-1:0][AW-1:0]   bases
);
    // Base storage with nonzero-only update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bases <= RST_BASES;
        end else if (wr && (val != '0) && (int'(sel) < NWIN)) begin
            bases[sel] <= val;
        end
    end
endmodule

// File: rtl/pio_dev_select.sv
// Per-channel master/slave select flags, updated by the decoder when a
// legal select-register write is accepted.
module pio_dev_select (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic       upd_chan,
    input  logic       upd_val,
    output logic [1:0] flags
);
    // Flag register per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= 2'b00;
        end else if (upd) begin
            flags[upd_chan] <= upd_val;
        end
    end
endmodule

// File: rtl/pio_xfer_split.sv
// Issues drive transfers. A wide request emits the low half in the cycle
// after start and the high half in the next; ready is low in between.
// Assumes start is only raised while ready is high.
module pio_xfer_split #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wide,
    input  logic          write,
    input  logic [1:0]    idx,
    input  logic [1:0]    cls,
    input  logic [AW-1:0] ofs,
    input  logic [31:0]   wdata,
    output logic          ready,
    output logic          drv_valid,
    output logic          drv_write,
    output logic [1:0]    drv_idx,
    output logic [1:0]    drv_class,
    output logic [AW-1:0] drv_offset,
    output logic [15:0]   drv_wdata,
    output logic          drv_hi
);
    logic        pending;
    logic [15:0] hi_data;

    // Transfer sequencer: first half on start, second half one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            hi_data    <= '0;
            drv_valid  <= 1'b0;
            drv_write  <= 1'b0;
            drv_idx    <= '0;
            drv_class  <= '0;
            drv_offset <= '0;
            drv_wdata  <= '0;
            drv_hi     <= 1'b0;
        end else begin
            drv_valid <= 1'b0;
            drv_hi    <= 1'b0;
            if (pending) begin
                drv_valid <= 1'b1;
                drv_hi    <= 1'b1;
                drv_wdata <= hi_data;
                pending   <= 1'b0;
            end else if (start) begin
                drv_valid  <= 1'b1;
                drv_write  <= write;
                drv_idx    <= idx;
                drv_class  <= cls;
                drv_offset <= ofs;
                drv_wdata  <= wdata[15:0];
                hi_data    <= wdata[31:16];
                pending    <= wide;
            end
        end
    end

    // New accesses wait while a second half is owed.
    assign ready = !pending;
endmodule

// File: rtl/pio_window_decoder.sv
// Top of the two-channel disk register address decoder. Decodes accepted
// accesses against five prioritised windows, tracks the device-select flags
// and drives the transfer sequencer. Assumes acc_valid is only raised while
// acc_ready is high.
module pio_window_decoder
    import pio_dec_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            CMD_SIZE   = 8,
    parameter int            CTRL_SIZE  = 4,
    parameter int            BM_SIZE    = 16,
    parameter int            BM_CH1_OFS = 8,
    parameter int            DATA_OFS   = 0,
    parameter int            SEL_OFS    = 6,
    parameter int            DEV_BIT    = 4,
    parameter logic [AW-1:0] RST_PCMD   = AW'(16'h01F0),
    parameter logic [AW-1:0] RST_PCTL   = AW'(16'h03F4),
    parameter logic [AW-1:0] RST_SCMD   = AW'(16'h0170),
    parameter logic [AW-1:0] RST_SCTL   = AW'(16'h0374),
    parameter logic [AW-1:0] RST_BM     = AW'(16'hC000)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_en,
    input  logic          base_wr,
    input  logic [2:0]    base_sel,
    input  logic [AW-1:0] base_val,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [1:0]    acc_size,
    input  logic [AW-1:0] acc_addr,
    input  logic [31:0]   acc_wdata,
    input  logic [3:0]    drive_present,
    output logic          acc_ready,
    output logic          rsp_valid,
    output logic [1:0]    rsp_class,
    output logic          rsp_chan,
    output logic [AW-1:0] rsp_offset,
    output logic          decode_err,
    output logic          size_err,
    output logic [1:0]    sel_flags,
    output logic          drv_valid,
    output logic          drv_write,
    output logic [1:0]    drv_idx,
    output logic [1:0]    drv_class,
    output logic [AW-1:0] drv_offset,
    output logic [15:0]   drv_wdata,
    output logic          drv_hi
);
    localparam logic [NWIN*AW-1:0] RST_BASES = {RST_BM, RST_SCTL, RST_SCMD, RST_PCTL, RST_PCMD};
    localparam int WSIZE [NWIN] = '{CMD_SIZE, CTRL_SIZE, CMD_SIZE, CTRL_SIZE, BM_SIZE};
    localparam logic [AW-1:0] DATA_O  = AW'(DATA_OFS);
    localparam logic [AW-1:0] SEL_O   = AW'(SEL_OFS);
    localparam logic [AW-1:0] SPLIT_O = AW'(BM_CH1_OFS);

    logic [NWIN-1:0][AW-1:0] bases;
    logic [NWIN-1:0]         hit;
    logic [NWIN-1:0][AW-1:0] win_ofs;

    logic          any_hit;
    logic [2:0]    win_idx;
    reg_class_t    cls;
    logic          chan;
    logic [AW-1:0] ofs;
    logic          size_ok;
    logic          take;
    logic          sel_upd;
    logic          flag_eff;
    logic [1:0]    idx;
    logic          start;
    logic          wide;

    pio_base_regs #(.AW(AW), .RST_BASES(RST_BASES)) u_bases (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (base_wr),
        .sel   (base_sel),
        .val   (base_val),
        .bases (bases)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        pio_win_cmp #(.AW(AW), .SIZE(WSIZE[g])) u_cmp (
            .addr   (acc_addr),
            .base   (bases[g]),
            .hit    (hit[g]),
            .offset (win_ofs[g])
        );
    end

    // Priority pick: the lowest numbered matching window wins.
    always_comb begin
        win_idx = 3'd0;
        any_hit = 1'b0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                win_idx = 3'(i);
                any_hit = 1'b1;
            end
        end
    end

    // Class, channel and offset of the selected window.
    always_comb begin
        ofs  = win_ofs[win_idx];
        cls  = RC_NONE;
        chan = 1'b0;
        if (any_hit) begin
            case (int'(win_idx))
                WIN_PCMD: begin cls = RC_CMD;  chan = 1'b0; end
                WIN_PCTL: begin cls = RC_CTRL; chan = 1'b0; end
                WIN_SCMD: begin cls = RC_CMD;  chan = 1'b1; end
                WIN_SCTL: begin cls = RC_CTRL; chan = 1'b1; end
                default:  begin cls = RC_BM;   chan = (ofs >= SPLIT_O); end
            endcase
        end
    end

    // Width legality per register class.
    always_comb begin
        case (cls)
            RC_CMD:  size_ok = (ofs == DATA_O) ? (acc_size == SZ_16 || acc_size == SZ_32)
                                               : (acc_size == SZ_8);
            RC_CTRL: size_ok = (acc_size == SZ_8);
            RC_BM:   size_ok = (acc_size != SZ_BAD);
            default: size_ok = 1'b0;
        endcase
    end

    // Acceptance, select update and transfer start.
    always_comb begin
        take     = acc_valid && acc_ready && io_en;
        sel_upd  = take && any_hit && (cls == RC_CMD) && (ofs == SEL_O) && acc_write && size_ok;
        flag_eff = sel_upd ? acc_wdata[DEV_BIT] : sel_flags[chan];
        idx      = {chan, flag_eff};
        start    = take && any_hit && size_ok && (cls != RC_BM) && drive_present[idx];
        wide     = (cls == RC_CMD) && (ofs == DATA_O) && (acc_size == SZ_32);
    end

    pio_dev_select u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (sel_upd),
        .upd_chan (chan),
        .upd_val  (acc_wdata[DEV_BIT]),
        .flags    (sel_flags)
    );

    pio_xfer_split #(.AW(AW)) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .wide       (wide),
        .write      (acc_write),
        .idx        (idx),
        .cls        (cls),
        .ofs        (ofs),
        .wdata      (acc_wdata),
        .ready      (acc_ready),
        .drv_valid  (drv_valid),
        .drv_write  (drv_write),
        .drv_idx    (drv_idx),
        .drv_class  (drv_class),
        .drv_offset (drv_offset),
        .drv_wdata  (drv_wdata),
        .drv_hi     (drv_hi)
    );

    // Response register: one pulse per accepted enabled access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_class  <= RC_CMD;
            rsp_chan   <= 1'b0;
            rsp_offset <= '0;
            decode_err <= 1'b0;
            size_err   <= 1'b0;
        end else begin
            rsp_valid  <= take;
            decode_err <= take && !any_hit;
            size_err   <= take && any_hit && !size_ok;
            if (take) begin
                rsp_class  <= cls;
                rsp_chan   <= chan;
                rsp_offset <= any_hit ? ofs : '0;
            end
        end
    end
endmodule

// File: rtl/pio_window_decoder_chk.sv
// Temporal checks on the decoder ports, bound into every instance.
module pio_window_decoder_chk #(
    parameter int AW = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       io_en,
    input logic       acc_valid,
    input logic       acc_ready,
    input logic       rsp_valid,
    input logic [1:0] rsp_class,
    input logic       rsp_chan,
    input logic       decode_err,
    input logic       size_err,
    input logic [1:0] sel_flags,
    input logic       drv_valid,
    input logic [1:0] drv_idx,
    input logic       drv_hi
);
    AST_SPLIT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_valid && !drv_hi && !acc_ready) |=> (drv_valid && drv_hi)); // R7
    AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        drv_hi |-> (drv_valid && $past(drv_valid && !drv_hi))); // R7
    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ready |=> acc_ready); // R7
    AST_IO_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && !io_en) |=> (!rsp_valid && !decode_err && !size_err)); // R5
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_ready && io_en) |=> $stable(sel_flags)); // R3
    AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_err || size_err) |-> !drv_valid); // R8
    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({decode_err, size_err})); // R10
    AST_BM_NO_DRV: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_class == 2'd2) |-> !drv_valid); // R2
    AST_IDX_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        drv_valid |-> (drv_idx[1] == rsp_chan)); // R4
endmodule

bind pio_window_decoder pio_window_decoder_chk #(.AW(AW)) u_chk (.*);

// File: tb/pio_window_decoder_test.sv
module pio_window_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_en = 1'b0;
    logic          base_wr = 1'b0;
    logic [2:0]    base_sel = '0;
    logic [AW-1:0] base_val = '0;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic [1:0]    acc_size = '0;
    logic [AW-1:0] acc_addr = '0;
    logic [31:0]   acc_wdata = '0;
    logic [3:0]    drive_present = 4'hF;

    logic          acc_ready, rsp_valid, rsp_chan, decode_err, size_err;
    logic [1:0]    rsp_class, sel_flags, drv_idx, drv_class;
    logic [AW-1:0] rsp_offset, drv_offset;
    logic          drv_valid, drv_write, drv_hi;
    logic [15:0]   drv_wdata;

    pio_window_decoder uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    // Reference model state
    int mbase [5];
    int msz   [5] = '{8, 4, 8, 4, 16};
    bit mflag [2];
    bit pend;
    int pend_hi;
    int e_rv, e_cls, e_ch, e_ofs, e_de, e_se, e_fl, e_dv, e_dw, e_idx, e_dc, e_do, e_dd, e_hi, e_rdy;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural cycle model, evaluated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mbase = '{'h1F0, 'h3F4, 'h170, 'h374, 'hC000};
            mflag = '{0, 0};
            pend = 0;
            e_rv = 0; e_de = 0; e_se = 0; e_dv = 0; e_hi = 0; e_fl = 0; e_rdy = 1;
        end else begin
            int w, o, c, ch, d;
            bit ok;
            e_rv = 0; e_de = 0; e_se = 0; e_dv = 0; e_hi = 0;
            if (pend) begin
                e_dv = 1; e_hi = 1; e_dd = pend_hi; pend = 0;
            end else if (acc_valid && io_en) begin
                w = -1;
                for (int k = 0; k < 5; k++)
                    if (w < 0 && int'(acc_addr) >= mbase[k] && int'(acc_addr) < mbase[k] + msz[k]) w = k;
                e_rv = 1;
                if (w < 0) begin
                    e_cls = 3; e_ch = 0; e_ofs = 0; e_de = 1;
                end else begin
                    o  = int'(acc_addr) - mbase[w];
                    c  = (w == 4) ? 2 : (w % 2);
                    ch = (w == 4) ? int'(o >= 8) : w / 2;
                    if (c == 2)      ok = (acc_size != 3);
                    else if (c == 1) ok = (acc_size == 0);
                    else             ok = (o == 0) ? (acc_size == 1 || acc_size == 2) : (acc_size == 0);
                    e_se = !ok; e_cls = c; e_ch = ch; e_ofs = o;
                    if (ok && c == 0 && o == 6 && acc_write) mflag[ch] = acc_wdata[4];
                    if (ok && c != 2) begin
                        d = ch * 2 + int'(mflag[ch]);
                        if (drive_present[d]) begin
                            e_dv = 1; e_dw = acc_write; e_idx = d; e_dc = c; e_do = o;
                            e_dd = acc_wdata[15:0];
                            if (c == 0 && o == 0 && acc_size == 2) begin
                                pend = 1; pend_hi = acc_wdata[31:16];
                            end
                        end
                    end
                end
            end
            if (base_wr && base_val != 0 && base_sel < 5) mbase[base_sel] = base_val;
            e_fl = {mflag[1], mflag[0]};
            e_rdy = !pend;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R7 ready", acc_ready, e_rdy);
            chk("R5 rsp_valid", rsp_valid, e_rv);
            chk("R10 decode_err", decode_err, e_de);
            chk("R8 size_err", size_err, e_se);
            chk("R3 sel_flags", sel_flags, e_fl);
            chk("R6 drv_valid", drv_valid, e_dv);
            chk("R7 drv_hi", drv_hi, e_hi);
            if (e_rv) begin
                chk("R1 rsp_class", rsp_class, e_cls);
                chk("R2 rsp_chan", rsp_chan, e_ch);
                chk("R9 rsp_offset", rsp_offset, e_ofs);
            end
            if (e_dv) begin
                chk("R4 drv_idx", drv_idx, e_idx);
                chk("R7 drv_write", drv_write, e_dw);
                chk("R7 drv_class", drv_class, e_dc);
                chk("R7 drv_offset", drv_offset, e_do);
                chk("R7 drv_wdata", drv_wdata, e_dd);
            end
        end
    end

    task automatic acc(input int addr, input int sz, input bit wr, input int data);
        while (!acc_ready) @(negedge clk);
        acc_valid = 1; acc_addr = AW'(addr); acc_size = 2'(sz); acc_write = wr; acc_wdata = data;
        @(negedge clk);
        acc_valid = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic setbase(input int sel, input int val);
        base_wr = 1; base_sel = 3'(sel); base_val = AW'(val);
        @(negedge clk);
        base_wr = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 ready", acc_ready, 1);
        chk("R11 rsp_valid", rsp_valid, 0);
        chk("R11 drv_valid", drv_valid, 0);
        chk("R11 sel_flags", sel_flags, 0);
        cmp_on = 1;
        io_en = 1;
        // R1 window edges and R10 misses
        acc('h1F7, 0, 0, 0);
        acc('h1F0, 1, 0, 0);
        acc('h1F8, 0, 0, 0);
        acc('h1EF, 0, 0, 0);
        acc('h3F4, 0, 1, 'h5A);
        acc('h3F7, 0, 0, 0);
        acc('h3F8, 0, 0, 0);
        acc('h177, 0, 0, 0);
        acc('h374, 0, 1, 'h01);
        // R2 bus-master channel split
        acc('hC000, 2, 1, 'h1234);
        acc('hC007, 0, 0, 0);
        acc('hC008, 1, 0, 0);
        acc('hC00F, 0, 1, 3);
        acc('hC010, 0, 0, 0);
        acc('hC004, 3, 0, 0);
        // R3 select flag writes and non-updates
        acc('h1F6, 0, 1, 'h10);
        acc('h176, 0, 1, 'hF0);
        acc('h176, 0, 1, 'hEF);
        acc('h1F6, 0, 0, 0);
        acc('h3F6, 0, 1, 'h00);
        // R4 drive numbering on all channels
        acc('h1F0, 1, 1, 'hBEEF);
        acc('h170, 1, 0, 0);
        acc('h176, 0, 1, 'h10);
        acc('h171, 0, 1, 'h77);
        // R7 split word transfers
        acc('h1F0, 2, 1, 'hAABBCCDD);
        acc('h170, 2, 0, 0);
        acc('h3F4, 0, 0, 0);
        // R8 width errors
        acc('h1F7, 1, 0, 0);
        acc('h1F0, 0, 1, 'h44);
        acc('h1F0, 3, 1, 'h44);
        acc('h1F6, 1, 1, 'h00);
        acc('h3F5, 2, 0, 0);
        // R6 absent slots
        drive_present = 4'b1011;
        acc('h176, 0, 1, 'h00);
        acc('h170, 2, 1, 'h11112222);
        drive_present = 4'b0101;
        acc('h1F0, 1, 0, 0);
        drive_present = 4'hF;
        // R5 disabled I/O space
        io_en = 0;
        acc('h1F6, 0, 1, 'h00);
        acc('h1F8, 0, 0, 0);
        acc('h1F0, 2, 1, 'h99998888);
        io_en = 1;
        // R9 base updates and R1 priority under overlap
        setbase(2, 0);
        acc('h170, 0, 0, 0);
        setbase(2, 'h1F4);
        acc('h1F5, 0, 0, 0);
        acc('h1FA, 0, 1, 'h10);
        acc('h1F8, 1, 0, 0);
        acc('h170, 0, 0, 0);
        setbase(7, 'h55);
        setbase(4, 'h0800);
        acc('h0808, 0, 0, 0);
        acc('hC000, 0, 0, 0);
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule